// File: doc/BRIEF.md
# Multichannel Complex Sample Buffer Writer

This block takes complex samples from four receive channels that arrive together, one set per sample time, and writes them as single words into one flat sample memory. Each complex value takes two consecutive words, the real word first. Up to one set of four channel pairs is taken per handshake. The eight words are then sent out one per cycle on a plain memory write port.

Two layouts are selected at run time. In the contiguous layout, every sample of channel 0 for the whole chirp is stored in sample order before channel 1 begins, and so on. In the interleaved layout, all four channels of one sample time are stored next to each other before the next sample time. The chirp length N (samples per chirp) and the layout are taken when the first sample of a chirp is accepted. A one-cycle frame-done flag marks the end of the chirp's 8*N words. The next chirp then starts again at the base address.

Top module: `cplx_buf_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, in_ready is 1, wr_en is 0 and frame_done is 0.
- R2: A sample accepted on a clock edge (in_valid and in_ready both 1) gives exactly eight writes on the eight following cycles. They come in the order ch0 real, ch0 imag, ch1 real, ch1 imag, ch2 real, ch2 imag, ch3 real, ch3 imag. Channel c's real word is in_re[16c+15:16c] and its imaginary word is in_im[16c+15:16c].
- R3: in_ready is 0 during each of the eight write cycles. Changes on in_re/in_im after the accepting edge do not change the words written.
- R4: With layout 1 (interleaved), the word for channel c, sample n, part p (0 real, 1 imag) goes to BASE + 2*(4*n + c) + p.
- R5: With layout 0 (contiguous), that word goes to BASE + 2*(c*N + n) + p, where N is the latched chirp length.
- R6: mode_ilv and chirp_len are sampled only when sample 0 of a chirp is accepted. Changes made during a chirp take effect from the next chirp.
- R7: frame_done is 1 for exactly one cycle: the cycle after the last write of sample N-1. The next accepted sample is sample 0 of a new chirp, written from BASE.
- R8: The first sample of the next chirp can be accepted in the same cycle that frame_done is 1. Its writes then start on the following cycle.
- R9: A chirp_len of 0 is handled as a chirp length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Writer can take a sample set |
| in_re | input | 64 | Real words, channel c at bits 16c+15:16c |
| in_im | input | 64 | Imaginary words, channel c at bits 16c+15:16c |
| mode_ilv | input | 1 | Layout select: 1 interleaved, 0 contiguous |
| chirp_len | input | 8 | Samples per chirp |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 12 | Memory word address |
| wr_data | output | 16 | Memory write word |
| frame_done | output | 1 | One-cycle end-of-chirp pulse |

## Verification
Two functions can happen in the same cycle: the end-of-chirp pulse and the acceptance of the next chirp's first sample, together with the latching of that chirp's new layout and length. The bench keeps in_valid high in the frame_done cycle with a different mode on mode_ilv. It then checks that frame_done and in_ready are both 1 in that cycle, and that the very next write lands at BASE using the new layout. A mid-chirp change of mode and length is also driven, and the bench checks that the remainder of the chirp keeps the layout and length latched at sample 0.

// File: rtl/cbw_pkg.sv
// Shared types for the complex sample buffer writer.
package cbw_pkg;
    typedef enum logic {
        LAYOUT_CONTIG = 1'b0,
        LAYOUT_ILV    = 1'b1
    } layout_e;
endpackage

// File: rtl/cbw_capture.sv
// Holds one accepted set of channel pairs and selects the word to write.
// Assumes load is only asserted when the sequencer is idle.
module cbw_capture #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 16,
    localparam int WPS   = 2 * NUM_CH,
    localparam int K_W   = $clog2(WPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NUM_CH*WORD_W-1:0] in_re,
    input  logic [NUM_CH*WORD_W-1:0] in_im,
    input  logic [K_W-1:0]           word_idx,
    output logic [WORD_W-1:0]        word_out
);
    logic [WORD_W-1:0] hold [WPS];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Latch the real and imaginary word of channel c on acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold[2*c]   <= '0;
                hold[2*c+1] <= '0;
            end else if (load) begin
                hold[2*c]   <= in_re[c*WORD_W +: WORD_W];
                hold[2*c+1] <= in_im[c*WORD_W +: WORD_W];
            end
        end
    end

    // Real word of a channel sits at an even index, imaginary at the odd one.
    assign word_out = hold[word_idx];
endmodule

// File: rtl/cbw_seq.sv
// Write sequencer: steps through the eight words of a sample and counts
// samples within a chirp. Latches layout and length at sample 0.
module cbw_seq #(
    parameter int NUM_CH = 4,
    parameter int LEN_W  = 8,
    localparam int WPS   = 2 * NUM_CH,
    localparam int K_W   = $clog2(WPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 mode_ilv,
    input  logic [LEN_W-1:0]     chirp_len,
    output logic                 in_ready,
    output logic                 busy,
    output logic [K_W-1:0]       word_idx,
    output logic [LEN_W-1:0]     samp_idx,
    output cbw_pkg::layout_e     layout_q,
    output logic [LEN_W-1:0]     len_q,
    output logic                 frame_done
);
    import cbw_pkg::*;

    logic accept;
    logic last_word;
    logic last_samp;

    assign in_ready  = !busy;
    assign accept    = in_valid && !busy;
    assign last_word = (word_idx == K_W'(WPS - 1));
    assign last_samp = (samp_idx == len_q - LEN_W'(1));

    // Counter, chirp-settings latch and end-of-chirp pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            word_idx   <= '0;
            samp_idx   <= '0;
            layout_q   <= LAYOUT_CONTIG;
            len_q      <= LEN_W'(1);
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                word_idx <= '0;
                if (samp_idx == '0) begin
                    layout_q <= layout_e'(mode_ilv);
                    len_q    <= (chirp_len == '0) ? LEN_W'(1) : chirp_len;
                end
            end else if (busy) begin
                if (last_word) begin
                    busy <= 1'b0;
                    if (last_samp) begin
                        samp_idx   <= '0;
                        frame_done <= 1'b1;
                    end else begin
                        samp_idx <= samp_idx + LEN_W'(1);
                    end
                end else begin
                    word_idx <= word_idx + K_W'(1);
                end
            end
        end
    end

    // R7: the end-of-chirp pulse never lasts two cycles.
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R6: chirp settings do not move while a later sample is being written.
    a_r6_layout_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && samp_idx != '0) |-> ($stable(layout_q) && $stable(len_q)));

    // R9: the latched length is never zero.
    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        len_q != '0);
endmodule

// File: rtl/cbw_addr.sv
// Address generator for both layouts. Combinational from sequencer state.
// Assumes addresses fit in ADDR_W bits for the largest chirp used.
module cbw_addr #(
    parameter int NUM_CH    = 4,
    parameter int LEN_W     = 8,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 64,
    localparam int WPS      = 2 * NUM_CH,
    localparam int K_W      = $clog2(WPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  cbw_pkg::layout_e     layout_q,
    input  logic [LEN_W-1:0]     len_q,
    input  logic [LEN_W-1:0]     samp_idx,
    input  logic [K_W-1:0]       word_idx,
    output logic [ADDR_W-1:0]    addr
);
    import cbw_pkg::*;

    logic [ADDR_W-1:0] chan, part, samp, len, ilv_off, ctg_off;

    // Split the word index into channel and real/imaginary part.
    always_comb begin
        chan    = ADDR_W'(word_idx >> 1);
        part    = ADDR_W'(word_idx[0]);
        samp    = ADDR_W'(samp_idx);
        len     = ADDR_W'(len_q);
        ilv_off = samp * ADDR_W'(WPS) + ADDR_W'(word_idx);
        ctg_off = ((chan * len + samp) << 1) + part;
        addr    = ADDR_W'(BASE_ADDR) + ((layout_q == LAYOUT_ILV) ? ilv_off : ctg_off);
    end

    // R2: an imaginary word always goes right after its real word.
    a_r2_imag_after_real: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && word_idx[0]) |-> (addr == $past(addr) + ADDR_W'(1)));
endmodule

// File: rtl/cplx_buf_writer.sv
// Top: accepts four channel pairs per handshake and writes them as eight
// words to a flat memory, interleaved or contiguous by chirp.
module cplx_buf_writer #(
    parameter int NUM_CH    = 4,
    parameter int WORD_W    = 16,
    parameter int LEN_W     = 8,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 64,
    localparam int WPS      = 2 * NUM_CH,
    localparam int K_W      = $clog2(WPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [NUM_CH*WORD_W-1:0] in_re,
    input  logic [NUM_CH*WORD_W-1:0] in_im,
    input  logic                     mode_ilv,
    input  logic [LEN_W-1:0]         chirp_len,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [WORD_W-1:0]        wr_data,
    output logic                     frame_done
);
    import cbw_pkg::*;

    logic             busy;
    logic [K_W-1:0]   word_idx;
    logic [LEN_W-1:0] samp_idx;
    logic [LEN_W-1:0] len_q;
    layout_e          layout_q;

    cbw_seq #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_ilv(mode_ilv),
        .chirp_len(chirp_len), .in_ready(in_ready), .busy(busy),
        .word_idx(word_idx), .samp_idx(samp_idx), .layout_q(layout_q),
        .len_q(len_q), .frame_done(frame_done)
    );

    cbw_capture #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .load(in_valid && in_ready),
        .in_re(in_re), .in_im(in_im), .word_idx(word_idx), .word_out(wr_data)
    );

    cbw_addr #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
               .BASE_ADDR(BASE_ADDR)) u_addr (
        .clk(clk), .rst_n(rst_n), .busy(busy), .layout_q(layout_q),
        .len_q(len_q), .samp_idx(samp_idx), .word_idx(word_idx), .addr(wr_addr)
    );

    // A write happens in every busy cycle.
    assign wr_en = busy;

    // R3: no new sample is taken while words are going out.
    a_r3_no_accept_writing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_ready);

    // R2: a write burst only starts after a handshake.
    a_r2_burst_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(in_valid && in_ready));

    // R7: the end-of-chirp pulse follows a write.
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(wr_en));
endmodule

// File: tb/sim_cplx_buf_writer.sv
module sim_cplx_buf_writer;
    localparam int BASE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_re = '0;
    logic [63:0] in_im = '0;
    logic        mode_ilv = 1'b0;
    logic [7:0]  chirp_len = 8'd1;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [15:0] wr_data;
    logic        frame_done;

    int checks = 0;
    int errors = 0;
    int b_n = 0;
    int b_len = 1;
    logic b_mode = 1'b0;

    always #5 clk = ~clk;

    cplx_buf_writer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_re(in_re), .in_im(in_im), .mode_ilv(mode_ilv), .chirp_len(chirp_len),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .frame_done(frame_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sends one sample set and checks its eight writes and the cycle after.
    task automatic send_sample(input logic mode, input int len_drive, input int seed);
        if (b_n == 0) begin
            b_mode = mode;
            b_len  = (len_drive == 0) ? 1 : len_drive;
        end
        chk("R8", "ready at offer", int'(in_ready), 1);
        in_valid  = 1'b1;
        mode_ilv  = mode;
        chirp_len = 8'(len_drive);
        for (int c = 0; c < 4; c++) begin
            in_re[c*16 +: 16] = 16'(seed*16 + 2*c);
            in_im[c*16 +: 16] = 16'(seed*16 + 2*c + 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_re = ~in_re;
        in_im = ~in_im;
        for (int k = 0; k < 8; k++) begin
            int c = k / 2;
            int p = k % 2;
            int ea = b_mode ? BASE + 2*(4*b_n + c) + p
                            : BASE + 2*(c*b_len + b_n) + p;
            chk("R2", "wr_en", int'(wr_en), 1);
            chk("R3", "ready low", int'(in_ready), 0);
            chk("R2", "data order", int'(wr_data), (seed*16 + k) & 16'hFFFF);
            chk(b_mode ? "R4" : "R5", "address", int'(wr_addr), ea);
            @(negedge clk);
        end
        chk("R2", "burst end", int'(wr_en), 0);
        if (b_n == b_len - 1) begin
            chk("R7", "frame_done", int'(frame_done), 1);
            chk("R8", "ready with done", int'(in_ready), 1);
            b_n = 0;
        end else begin
            chk("R7", "no frame_done", int'(frame_done), 0);
            b_n++;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", int'(in_ready), 1);
        chk("R1", "wr_en in reset", int'(wr_en), 0);
        chk("R1", "done in reset", int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", int'(in_ready), 1);
        chk("R1", "wr_en after reset", int'(wr_en), 0);
    endtask

    task automatic t_frame(input logic mode, input int len, input int seed);
        for (int n = 0; n < len; n++) send_sample(mode, len, seed + n);
    endtask

    // R6: changes during a chirp wait for the next chirp.
    task automatic t_mode_midchirp;
        send_sample(1'b1, 2, 40);
        send_sample(1'b0, 5, 41);
        chk("R6", "chirp closed on old length", b_n, 0);
        send_sample(1'b0, 1, 42);
    endtask

    // R9: a zero length behaves like one sample per chirp.
    task automatic t_len_zero;
        send_sample(1'b0, 0, 60);
        send_sample(1'b1, 0, 61);
    endtask

    initial begin
        t_reset();
        t_frame(1'b1, 3, 1);
        t_frame(1'b0, 3, 10);
        t_frame(1'b1, 2, 20);
        t_mode_midchirp();
        t_frame(1'b0, 1, 50);
        t_len_zero();
        t_frame(1'b0, 4, 70);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule